// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a clocked, synthesizable model of a 16-bit-wide static memory with an asynchronous-style control interface. The depth is set by a parameter. The default address width is 10 bits so that elaboration stays small. It can be raised to 18 bits to cover a full 256K-word space. On each rising clock the model samples two chip selects of opposite polarity, an active-low write strobe, an active-low read strobe and two active-low byte-lane enables.

A write stores the enabled byte lanes at every clock where the write condition holds. A read presents the stored word on the following clock, together with a per-lane drive vector that stands in for tri-state pins. A mode code reports standby, read, write or active-idle.

The address splits into a 4-bit word index (bits 3:0) and a page number (the bits above). The model reports when a read stays in the page of the previous read, and it counts reads that open a new page. A system that wants to exploit cheap in-page accesses can use these to judge its access pattern.

Top module: `sram_bytelane_model`

## Requirements
- R1: The part is selected only when `cs_n` is 0 and `cs` is 1. Otherwise, one clock after sampling, `mode` is 0 (standby) and `dout_en` is 2'b00.
- R2: When `lane_lo_n` and `lane_hi_n` are both 1, the part is in standby (`mode` 0, `dout_en` 00) and nothing is written, whatever the other controls are.
- R3: When selected with at least one lane enabled and `wr_n` = 0, the cycle is a write (`mode` 2) whatever `rd_n` is, and `dout_en` is 00.
- R4: A write stores `din[7:0]` only if `lane_lo_n` = 0 and `din[15:8]` only if `lane_hi_n` = 0. The other lane of that word keeps its previous value.
- R5: A read is selected with `wr_n` = 1 and `rd_n` = 0. One clock after sampling, `mode` is 1 and `dout_en[0]`/`dout_en[1]` are set for the enabled low/high lanes. `dout` carries the stored bytes in enabled lanes and zero in disabled lanes. A read in the clock after a write to the same word returns the new data.
- R6: Selected with a lane enabled, `wr_n` = 1 and `rd_n` = 1, the part is active-idle: `mode` 3 and `dout_en` 00.
- R7: In standby, the address, data and strobes change no stored word.
- R8: `page_hit` is 1 one clock after a read whose address bits above bit 3 equal those of the previous read since reset, and 0 otherwise.
- R9: `page_opens` increments by one for each read whose page differs from the previous read's page. The first read after reset counts. No other cycle changes it.
- R10: Asynchronous reset clears `mode`, `dout_en`, `dout`, `page_hit` and `page_opens` to zero and forgets the open page. Stored words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cs | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low, overrides read strobe |
| rd_n | input | 1 | Output (read) strobe, active low |
| lane_lo_n | input | 1 | Low byte lane enable (bits 7:0), active low |
| lane_hi_n | input | 1 | High byte lane enable (bits 15:8), active low |
| addr | input | ADDR_W | Word address; bits 3:0 word in page, rest page |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero in undriven lanes |
| dout_en | output | 2 | Per-lane drive enable, bit 0 low lane |
| mode | output | 2 | 0 standby, 1 read, 2 write, 3 active-idle |
| page_hit | output | 1 | Last read stayed in the open page |
| page_opens | output | CNT_W | Count of reads that opened a page |

## Verification
A read that moves to a new page produces read data, a page-open count step and a cleared hit flag in the same clock. A read in the clock right after a write to the same word makes storage update and data return meet on consecutive edges. The stimulus table places such reads back to back with writes and page changes. Each row is judged by comparing data, lane drive, mode and hit flag with the expected row, and the page count is compared after the table. A reset in mid-run is then applied, and a read after it must count as a fresh page open while still returning the word stored before the reset.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  localparam int WORD_BITS = 4;
  localparam int LANES     = 2;
  localparam int LANE_W    = 8;
  localparam int DATA_W    = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_IDLE    = 2'd3
  } mode_e;

endpackage

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_model_pkg::*;
(
  input  logic             cs_n,
  input  logic             cs,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             lane_lo_n,
  input  logic             lane_hi_n,
  output mode_e            mode,
  output logic [LANES-1:0] wr_lane,
  output logic [LANES-1:0] rd_lane
);

  logic             selected;
  logic [LANES-1:0] lane_on;

  always_comb begin
    selected = !cs_n && cs;
    lane_on  = {!lane_hi_n, !lane_lo_n};
    if (!selected || (lane_on == '0)) begin
      mode = MODE_STANDBY;
    end else if (!wr_n) begin
      mode = MODE_WRITE;
    end else if (!rd_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_IDLE;
    end
    wr_lane = (mode == MODE_WRITE) ? lane_on : '0;
    rd_lane = (mode == MODE_READ)  ? lane_on : '0;
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];
  logic [LANE_W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[addr] <= wdata;
    end
  end

  always_comb begin
    rdata_d = rd_en ? store[addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_page_tracker.sv
module sram_page_tracker #(
  parameter int PAGE_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [PAGE_W-1:0] page,
  output logic              hit,
  output logic [CNT_W-1:0]  opens
);

  logic [PAGE_W-1:0] last_q, last_d;
  logic              valid_q, valid_d;
  logic              hit_d;
  logic [CNT_W-1:0]  opens_d;
  logic              same_page;

  always_comb begin
    same_page = valid_q && (page == last_q);
    last_d    = last_q;
    valid_d   = valid_q;
    opens_d   = opens;
    hit_d     = 1'b0;
    if (rd_fire) begin
      last_d  = page;
      valid_d = 1'b1;
      hit_d   = same_page;
      if (!same_page) begin
        opens_d = opens + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      valid_q <= 1'b0;
      hit     <= 1'b0;
      opens   <= '0;
    end else begin
      last_q  <= last_d;
      valid_q <= valid_d;
      hit     <= hit_d;
      opens   <= opens_d;
    end
  end

endmodule

// File: rtl/sram_bytelane_model.sv
module sram_bytelane_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    cs,
  input  logic                    wr_n,
  input  logic                    rd_n,
  input  logic                    lane_lo_n,
  input  logic                    lane_hi_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       din,
  output logic [DATA_W-1:0]       dout,
  output logic [LANES-1:0]        dout_en,
  output logic [1:0]              mode,
  output logic                    page_hit,
  output logic [CNT_W-1:0]        page_opens
);

  localparam int PAGE_W = ADDR_W - WORD_BITS;

  logic             rst_meta, rst_sync;
  mode_e            mode_d;
  logic [LANES-1:0] wr_lane, rd_lane;
  logic [LANES-1:0] en_d;
  logic [1:0]       mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sram_ctrl_decode u_decode (
    .cs_n      (cs_n),
    .cs        (cs),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .lane_lo_n (lane_lo_n),
    .lane_hi_n (lane_hi_n),
    .mode      (mode_d),
    .wr_lane   (wr_lane),
    .rd_lane   (rd_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_array #(.ADDR_W(ADDR_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_sync),
      .wr_en (wr_lane[g]),
      .rd_en (rd_lane[g]),
      .addr  (addr),
      .wdata (din[g*LANE_W +: LANE_W]),
      .rdata (dout[g*LANE_W +: LANE_W])
    );
  end

  sram_page_tracker #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_sync),
    .rd_fire (mode_d == MODE_READ),
    .page    (addr[ADDR_W-1:WORD_BITS]),
    .hit     (page_hit),
    .opens   (page_opens)
  );

  always_comb begin
    en_d = rd_lane;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      mode_q  <= 2'd0;
      dout_en <= '0;
    end else begin
      mode_q  <= mode_d;
      dout_en <= en_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/sram_bytelane_checker.sv
module sram_bytelane_checker #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cs,
  input logic              wr_n,
  input logic              rd_n,
  input logic              lane_lo_n,
  input logic              lane_hi_n,
  input logic [1:0]        dout_en,
  input logic [1:0]        mode,
  input logic              page_hit,
  input logic [CNT_W-1:0]  page_opens
);

  logic sel_any;
  assign sel_any = !cs_n && cs && !(lane_lo_n && lane_hi_n);

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs) |=> (mode == 2'd0 && dout_en == 2'b00));

  assert_lanes_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_lo_n && lane_hi_n) |=> (mode == 2'd0 && dout_en == 2'b00));

  assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && !wr_n) |=> (mode == 2'd2 && dout_en == 2'b00));

  assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && wr_n && !rd_n) |=>
      (mode == 2'd1 && dout_en == {!$past(lane_hi_n), !$past(lane_lo_n)}));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_any && wr_n && rd_n) |=> (mode == 2'd3 && dout_en == 2'b00));

  assert_hit_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_hit |-> (mode == 2'd1));

  assert_count_read_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd1 || page_hit) |-> $stable(page_opens));

endmodule

bind sram_bytelane_model sram_bytelane_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_sync),
  .cs_n       (cs_n),
  .cs         (cs),
  .wr_n       (wr_n),
  .rd_n       (rd_n),
  .lane_lo_n  (lane_lo_n),
  .lane_hi_n  (lane_hi_n),
  .dout_en    (dout_en),
  .mode       (mode),
  .page_hit   (page_hit),
  .page_opens (page_opens)
);

// File: tb/test_sram_bytelane_model.sv
module test_sram_bytelane_model;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 16;
  localparam int NVEC   = 14;

  typedef struct packed {
    logic        cs_n;
    logic        cs;
    logic        wr_n;
    logic        rd_n;
    logic        hi_n;
    logic        lo_n;
    logic [9:0]  addr;
    logic [15:0] din;
    logic [1:0]  emode;
    logic [1:0]  een;
    logic [15:0] edout;
    logic        ehit;
  } vec_t;

  // fields: cs_n cs wr_n rd_n hi_n lo_n addr din | mode en dout hit
  localparam vec_t TABLE [NVEC] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,10'h012,16'hA1B2, 2'd2,2'b00,16'h0000,1'b0}, // R4 both lanes
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,10'h013,16'h1122, 2'd2,2'b00,16'h0000,1'b0}, // R4 low only
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,10'h013,16'h3344, 2'd2,2'b00,16'h0000,1'b0}, // R4 high only
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,10'h012,16'h0000, 2'd1,2'b11,16'hA1B2,1'b0}, // R5 first read, R9
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,10'h013,16'h0000, 2'd1,2'b11,16'h3322,1'b1}, // R4 R8 hit
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,10'h013,16'h0000, 2'd1,2'b01,16'h0022,1'b1}, // R5 low lane
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,10'h020,16'h5566, 2'd2,2'b00,16'h0000,1'b0}, // R3 rd_n ignored
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,10'h020,16'h0000, 2'd1,2'b10,16'h5500,1'b0}, // R5 high lane, new page
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,10'h012,16'hFFFF, 2'd0,2'b00,16'h0000,1'b0}, // R1 R7 cs_n high
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,10'h012,16'hFFFF, 2'd0,2'b00,16'h0000,1'b0}, // R1 R7 cs low
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,10'h012,16'hFFFF, 2'd0,2'b00,16'h0000,1'b0}, // R2 lanes off
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,10'h012,16'h0000, 2'd3,2'b00,16'h0000,1'b0}, // R6 idle
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,10'h012,16'h0000, 2'd1,2'b11,16'hA1B2,1'b0}, // R7 R2 intact, miss
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,10'h012,16'h0000, 2'd1,2'b01,16'h00B2,1'b1}  // R8 hit
  };

  logic              clk;
  logic              rst_n;
  logic              cs_n, cs, wr_n, rd_n, lane_lo_n, lane_hi_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       din;
  logic [15:0]       dout;
  logic [1:0]        dout_en;
  logic [1:0]        mode;
  logic              page_hit;
  logic [CNT_W-1:0]  page_opens;

  int checks;
  int errors;

  sram_bytelane_model #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_sram_bytelane_model (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cs         (cs),
    .wr_n       (wr_n),
    .rd_n       (rd_n),
    .lane_lo_n  (lane_lo_n),
    .lane_hi_n  (lane_hi_n),
    .addr       (addr),
    .din        (din),
    .dout       (dout),
    .dout_en    (dout_en),
    .mode       (mode),
    .page_hit   (page_hit),
    .page_opens (page_opens)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a_cs_n, input logic a_cs, input logic a_wr_n,
                       input logic a_rd_n, input logic a_hi_n, input logic a_lo_n,
                       input logic [9:0] a_addr, input logic [15:0] a_din);
    cs_n = a_cs_n; cs = a_cs; wr_n = a_wr_n; rd_n = a_rd_n;
    lane_hi_n = a_hi_n; lane_lo_n = a_lo_n; addr = a_addr; din = a_din;
  endtask

  task automatic go_idle();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    go_idle();
    repeat (3) @(negedge clk);
    check("R10 reset mode", {30'd0, mode}, 32'd0);
    check("R10 reset dout_en", {30'd0, dout_en}, 32'd0);
    check("R10 reset dout", {16'd0, dout}, 32'd0);
    check("R10 reset count", {16'd0, page_opens}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(TABLE[i].cs_n, TABLE[i].cs, TABLE[i].wr_n, TABLE[i].rd_n,
            TABLE[i].hi_n, TABLE[i].lo_n, TABLE[i].addr, TABLE[i].din);
      @(negedge clk);
      check($sformatf("R1-table row %0d mode R11", i), {30'd0, mode}, {30'd0, TABLE[i].emode});
      check($sformatf("R5 row %0d dout_en", i), {30'd0, dout_en}, {30'd0, TABLE[i].een});
      check($sformatf("R4 row %0d dout", i), {16'd0, dout}, {16'd0, TABLE[i].edout});
      check($sformatf("R8 row %0d hit", i), {31'd0, page_hit}, {31'd0, TABLE[i].ehit});
    end
    go_idle();
    @(negedge clk);
    // opens: first read, move to page 2, back to page 1
    check("R9 page opens after table", {16'd0, page_opens}, 32'd3);

    // R5 write then read same word in the next clock
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h030, 16'h0BAD);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h030, 16'h0000);
    @(negedge clk);
    check("R5 read after write", {16'd0, dout}, 32'h0BAD);
    check("R9 new page counted", {16'd0, page_opens}, 32'd4);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h03F, 16'h0000);
    @(negedge clk);
    check("R9 hit does not count", {16'd0, page_opens}, 32'd4);
    check("R8 same page hit", {31'd0, page_hit}, 32'd1);
    go_idle();
    @(negedge clk);
    check("R8 hit cleared on non-read", {31'd0, page_hit}, 32'd0);

    // R10 reset in mid-run
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h030, 16'h0000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async clear dout_en", {30'd0, dout_en}, 32'd0);
    check("R10 async clear count", {16'd0, page_opens}, 32'd0);
    go_idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h030, 16'h0000);
    @(negedge clk);
    check("R10 contents kept", {16'd0, dout}, 32'h0BAD);
    check("R10 page forgotten, no hit", {31'd0, page_hit}, 32'd0);
    check("R9 first read after reset counts", {16'd0, page_opens}, 32'd1);
    go_idle();
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule